// File: doc/BRIEF.md
# Erase-Block Lock and Write-Protect Guard

This block keeps the protection state of a bottom-boot flash array with 39 erase blocks and rules on every operation the array controller wants to start. The array has eight small 4K-word blocks at the bottom and 31 main blocks of 32K words above them. The lowest two small blocks are boot blocks and the other six are parameter blocks. For each request, the guard takes the word address and finds the erase block it falls in. It then weighs three protection sources together with the program-voltage-OK input. The result is either a pass or a set of error flags for the status register.

The three sources cover different scopes. Each block has its own lock bit. A write-protect pin covers only the two boot blocks. A one-time permanent bit freezes the lock bits themselves.

The guard also carries out the lock-configuration operations: set one lock bit, clear all lock bits, and set the permanent bit. Lock state can be read back through an identifier read.

The lock bits and the permanent bit stand in for non-volatile cells. A soft reset leaves them untouched. Only the power-on initialisation input clears them.

Top module: `blk_guard`

## Requirements
- R1: Block index decode. A word address with bits 19:15 equal to zero selects small block bits 14:12 (0 to 7). Any other address selects main block 7 plus bits 19:15 (8 to 38). Blocks 0 and 1 are the boot blocks.
- R2: While wpN is low, blocks 0 and 1 count as locked whatever their lock bits hold. While wpN is high, they follow their lock bits. wpN has no effect on blocks 2 to 38.
- R3: A program (op 0) or block erase (op 1) to a locked block fails. The program raises prot and prog; the erase raises prot and erase. A response never carries prog and erase together.
- R4: When vppOk is low, every modifying op (0 to 5) fails with volt plus its matching error flag, and lock state does not change. The matching flag is prog for ops 0, 3 and 5, and erase for ops 1, 2 and 4. The voltage check takes priority over every lock check.
- R5: Set-lock (op 3) sets the lock bit of the addressed block. Clear-locks (op 4) clears all 39 lock bits in one operation.
- R6: While the permanent bit is set, set-lock fails with prot and prog, and clear-locks fails with prot and erase. In both cases the lock bits are left unchanged.
- R7: Set-permanent (op 5) sets the permanent bit, and it then stays set. Neither the permanent bit nor any lock bit changes when rstN is low. Only porN low clears them.
- R8: Chip erase (op 2) passes if any block is unlocked, counting the effect of wpN. It raises prot and erase only when all 39 blocks are locked.
- R9: An identifier read (op 6) returns the permanent bit on respId when the word address is exactly 3. At word offset 2 from a block's base address, it returns that block's stored lock bit, without the wpN effect. At any other address it returns 0. The read always passes.
- R10: Each accepted request gets exactly one response, with respValid high on the clock edge after the request. With no request, respValid is low. On a pass, respFlags is zero. respFlags bit 0 is prog, bit 1 is erase, bit 2 is prot and bit 3 is volt. Op codes: 0 program, 1 block erase, 2 chip erase, 3 set-lock, 4 clear-locks, 5 set-permanent, 6 identifier read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Soft reset, active low; clears the response path only |
| porN | input | 1 | Power-on initialisation, active low; clears all protection state |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqOp | input | 3 | Operation code (R10) |
| reqAddr | input | 20 | Word address of the request |
| wpN | input | 1 | Write-protect, active low, for the boot blocks |
| vppOk | input | 1 | Program voltage is within range |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respPass | output | 1 | The operation may proceed |
| respFlags | output | 4 | Error flags {volt, prot, erase, prog} |
| respId | output | 1 | Identifier read data bit |

## Verification
The assertions assume that wpN, vppOk and reqAddr are stable across the sampling edge of a request. They also assume that reqOp never carries the unused code 7 together with reqValid. The bench drives every input on the falling edge and draws op codes only from 0 to 6, so it stays within these assumptions. The assertions also take soft reset and power-on initialisation as clean low pulses held for at least one edge. The bench pulses each of them that way while no request is pending.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_ERASE   = 3'd1,
    OP_CHIP    = 3'd2,
    OP_SETLK   = 3'd3,
    OP_CLRLK   = 3'd4,
    OP_SETPERM = 3'd5,
    OP_READID  = 3'd6
  } opE;

  typedef struct packed {
    logic volt;
    logic prot;
    logic erase;
    logic prog;
  } flagT;

  typedef struct packed {
    logic setOne;
    logic clrAll;
    logic setPerm;
  } strobeT;
endpackage

// File: rtl/guard_data.sv
module guard_data
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SMALL_W = 12,
  parameter int MAIN_W  = 15,
  parameter int N_SMALL = 8,
  parameter int N_BOOT  = 2,
  parameter int N_BLK   = 39,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wpN,
  input  strobeT            strb,
  output logic [N_BLK-1:0]  lockVec,
  output logic              permBit,
  output logic              blkLocked,
  output logic              blkLockBit,
  output logic              allLocked,
  output logic              offTwo,
  output logic              permHit
);
  localparam int SEL_W = ADDR_W - MAIN_W;

  logic [SEL_W-1:0] mainSel;
  logic [IDX_W-1:0] blkIdx;
  logic [N_BLK-1:0] effLock;

  assign mainSel = reqAddr[ADDR_W-1:MAIN_W];

  always_comb begin
    if (mainSel == '0) begin
      blkIdx = IDX_W'(reqAddr[MAIN_W-1:SMALL_W]);
      offTwo = (reqAddr[SMALL_W-1:0] == SMALL_W'(2));
    end else begin
      blkIdx = IDX_W'(N_SMALL - 1) + IDX_W'(mainSel);
      offTwo = (reqAddr[MAIN_W-1:0] == MAIN_W'(2));
    end
  end

  assign permHit = (reqAddr == ADDR_W'(3));

  // Effective lock: boot blocks also follow the write-protect pin
  for (genvar g = 0; g < N_BLK; g++) begin : gEff
    if (g < N_BOOT) begin : gBoot
      assign effLock[g] = lockVec[g] | ~wpN;
    end else begin : gPlain
      assign effLock[g] = lockVec[g];
    end
  end

  assign blkLocked  = effLock[blkIdx];
  assign blkLockBit = lockVec[blkIdx];
  assign allLocked  = &effLock;

  // Protection state: cleared only by power-on initialisation
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lockVec <= '0;
      permBit <= 1'b0;
    end else begin
      if (strb.clrAll)      lockVec         <= '0;
      else if (strb.setOne) lockVec[blkIdx] <= 1'b1;
      if (strb.setPerm)     permBit         <= 1'b1;
    end
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       vppOk,
  input  logic       blkLocked,
  input  logic       blkLockBit,
  input  logic       allLocked,
  input  logic       permBit,
  input  logic       offTwo,
  input  logic       permHit,
  output strobeT     strb,
  output logic       respValid,
  output logic       respPass,
  output flagT       respFlags,
  output logic       respId
);
  opE   op;
  flagT flg;
  logic idBit;
  logic progKind;
  logic live;

  assign op       = opE'(reqOp);
  assign live     = reqValid & rstN;
  assign progKind = (op == OP_PROG) || (op == OP_SETLK) || (op == OP_SETPERM);

  always_comb begin
    flg   = '0;
    strb  = '0;
    idBit = 1'b0;
    if (live) begin
      if (op == OP_READID) begin
        idBit = permHit ? permBit : (offTwo & blkLockBit);
      end else if (op != opE'(3'd7)) begin
        if (!vppOk) begin
          flg.volt  = 1'b1;
          flg.prog  = progKind;
          flg.erase = ~progKind;
        end else begin
          unique case (op)
            OP_PROG:    if (blkLocked) begin flg.prot = 1'b1; flg.prog  = 1'b1; end
            OP_ERASE:   if (blkLocked) begin flg.prot = 1'b1; flg.erase = 1'b1; end
            OP_CHIP:    if (allLocked) begin flg.prot = 1'b1; flg.erase = 1'b1; end
            OP_SETLK:   if (permBit)   begin flg.prot = 1'b1; flg.prog  = 1'b1; end
                        else strb.setOne = 1'b1;
            OP_CLRLK:   if (permBit)   begin flg.prot = 1'b1; flg.erase = 1'b1; end
                        else strb.clrAll = 1'b1;
            OP_SETPERM: strb.setPerm = 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respPass  <= 1'b0;
      respFlags <= '0;
      respId    <= 1'b0;
    end else begin
      respValid <= live;
      respPass  <= live & (flg == '0);
      respFlags <= flg;
      respId    <= idBit;
    end
  end
endmodule

// File: rtl/blk_guard.sv
module blk_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SMALL_W = 12,
  parameter int MAIN_W  = 15,
  parameter int N_BOOT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wpN,
  input  logic              vppOk,
  output logic              respValid,
  output logic              respPass,
  output logic [3:0]        respFlags,
  output logic              respId
);
  localparam int N_SMALL = 1 << (MAIN_W - SMALL_W);
  localparam int N_MAIN  = (1 << (ADDR_W - MAIN_W)) - 1;
  localparam int N_BLK   = N_SMALL + N_MAIN;
  localparam int IDX_W   = $clog2(N_BLK);

  strobeT           strb;
  flagT             flg;
  logic [N_BLK-1:0] lockVec;
  logic permBit, blkLocked, blkLockBit, allLocked, offTwo, permHit;

  guard_data #(
    .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .MAIN_W(MAIN_W), .N_SMALL(N_SMALL),
    .N_BOOT(N_BOOT), .N_BLK(N_BLK), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .porN(porN), .reqAddr(reqAddr), .wpN(wpN), .strb(strb),
    .lockVec(lockVec), .permBit(permBit), .blkLocked(blkLocked),
    .blkLockBit(blkLockBit), .allLocked(allLocked), .offTwo(offTwo),
    .permHit(permHit)
  );

  guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .vppOk(vppOk),
    .blkLocked(blkLocked), .blkLockBit(blkLockBit), .allLocked(allLocked),
    .permBit(permBit), .offTwo(offTwo), .permHit(permHit), .strb(strb),
    .respValid(respValid), .respPass(respPass), .respFlags(flg), .respId(respId)
  );

  assign respFlags = flg;
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int ADDR_W  = 20,
  parameter int SMALL_W = 12,
  parameter int N_BOOT  = 2,
  parameter int N_BLK   = 39
) (
  input logic              clk,
  input logic              rstN,
  input logic              porN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              wpN,
  input logic              vppOk,
  input logic              respValid,
  input logic              respPass,
  input logic [3:0]        respFlags,
  input logic [N_BLK-1:0]  lockVec,
  input logic              permBit
);
  localparam logic [ADDR_W-1:0] BOOT_TOP = ADDR_W'(N_BOOT) << SMALL_W;

  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rstN || !porN)
    reqValid |=> respValid) else $error("resp timing");   // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !reqValid |=> !respValid) else $error("idle resp");   // R10
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (respValid && respPass) |-> (respFlags == 4'd0)) else $error("pass flags");   // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN || !porN)
    respValid |-> !(respFlags[0] && respFlags[1])) else $error("flag mix");   // R3
  AST_VOLT_ABORT: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && !vppOk && reqOp <= 3'd5) |=> (respFlags[3] && !respPass))
    else $error("volt abort");   // R4
  AST_BOOT_WP: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && vppOk && !wpN && reqOp <= 3'd1 && reqAddr < BOOT_TOP)
      |=> (respFlags[2] && !respPass)) else $error("boot wp");   // R2
  AST_PERM_FREEZE: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (permBit && reqValid && (reqOp == 3'd3 || reqOp == 3'd4)) |=> $stable(lockVec))
    else $error("perm freeze");   // R6
  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!porN)
    permBit |=> permBit) else $error("perm cleared");   // R7
endmodule

bind blk_guard guard_chk #(
  .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .N_BOOT(N_BOOT), .N_BLK(N_BLK)
) u_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .reqValid(reqValid), .reqOp(reqOp),
  .reqAddr(reqAddr), .wpN(wpN), .vppOk(vppOk), .respValid(respValid),
  .respPass(respPass), .respFlags(respFlags), .lockVec(lockVec), .permBit(permBit)
);

// File: tb/test_blk_guard.sv
`timescale 1ns/1ps
module test_blk_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0, porN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [19:0] reqAddr = '0;
  logic        wpN = 1'b1, vppOk = 1'b1;
  logic        respValid, respPass, respId;
  logic [3:0]  respFlags;

  int total = 0, bad = 0;
  bit done = 0;
  bit lockM [39];
  bit permM;

  always #2.5 clk = ~clk;

  blk_guard i_blk_guard (
    .clk(clk), .rstN(rstN), .porN(porN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .wpN(wpN), .vppOk(vppOk), .respValid(respValid),
    .respPass(respPass), .respFlags(respFlags), .respId(respId)
  );

  function automatic int blkOf(logic [19:0] a);
    return (a[19:15] == 0) ? int'(a[14:12]) : 7 + int'(a[19:15]);
  endfunction

  function automatic logic [19:0] baseOf(int b);
    return (b < 8) ? 20'(b << 12) : 20'((b - 7) << 15);
  endfunction

  function automatic bit effLk(int b, logic wp);
    return lockM[b] | (b < 2 && !wp);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    foreach (lockM[i]) lockM[i] = 0;
    permM = 0;
  endtask

  task automatic doReq(string tag, int op, logic [19:0] a, logic wp, logic vpp);
    int   b = blkOf(a);
    logic [3:0] ef = 0;
    logic eid = 0;
    bit   offTwo = (a[19:15] == 0) ? (a[11:0] == 2) : (a[14:0] == 2);
    logic [3:0] kind = (op == 0 || op == 3 || op == 5) ? 4'd1 : 4'd2;
    bit   allLk = 1;
    for (int i = 0; i < 39; i++) if (!effLk(i, wp)) allLk = 0;
    if (op == 6) begin
      eid = (a == 20'd3) ? permM : (offTwo ? lockM[b] : 1'b0);
    end else if (!vpp) begin
      ef = 4'd8 | kind;
    end else begin
      case (op)
        0, 1: if (effLk(b, wp)) ef = 4'd4 | kind;
        2:    if (allLk) ef = 4'd6;
        3:    if (permM) ef = 4'd5; else lockM[b] = 1;
        4:    if (permM) ef = 4'd6; else foreach (lockM[i]) lockM[i] = 0;
        5:    permM = 1;
        default: ;
      endcase
    end
    reqValid = 1'b1; reqOp = 3'(op); reqAddr = a; wpN = wp; vppOk = vpp;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " valid"}, 8'(respValid), 8'd1);
    chk({tag, " pass"},  8'(respPass),  8'(ef == 0));
    chk({tag, " flags"}, 8'(respFlags), 8'(ef));
    if (op == 6) chk({tag, " id"}, 8'(respId), 8'(eid));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd12345;
    clearModel();
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 8'(respValid), 8'd0);
    rstN = 1'b1; porN = 1'b1;
    @(negedge clk);
    chk("R10 idle", 8'(respValid), 8'd0);

    // R1 decode via set-lock and readback
    doReq("R1 set blk5", 3, 20'h05123, 1, 1);
    doReq("R1 rd blk5", 6, 20'h05002, 1, 1);
    doReq("R1 rd blk4", 6, 20'h04002, 1, 1);
    doReq("R1 set blk11", 3, 20'h23456, 1, 1);
    doReq("R1 rd blk11", 6, 20'h20002, 1, 1);
    doReq("R1 rd blk10", 6, 20'h18002, 1, 1);
    doReq("R1 set blk38", 3, 20'hF8010, 1, 1);
    doReq("R1 rd blk38", 6, 20'hF8002, 1, 1);
    doReq("R9 rd off3", 6, 20'hF8003, 1, 1);

    // R2 write-protect scope
    doReq("R5 clear", 4, 20'h00000, 1, 1);
    doReq("R2 boot wp low", 0, 20'h00100, 0, 1);
    doReq("R2 boot1 wp low", 1, 20'h01000, 0, 1);
    doReq("R2 boot wp high", 0, 20'h00100, 1, 1);
    doReq("R2 param wp low", 0, 20'h02000, 0, 1);
    doReq("R2 main wp low", 1, 20'h40000, 0, 1);

    // R3 locked block
    doReq("R5 set", 3, 20'h20000, 1, 1);
    doReq("R3 erase locked", 1, 20'h27FFF, 1, 1);
    doReq("R3 prog locked", 0, 20'h20010, 1, 1);
    doReq("R3 prog free", 0, 20'h28010, 1, 1);

    // R4 voltage priority
    doReq("R4 prog locked", 0, 20'h20010, 1, 0);
    doReq("R4 erase", 1, 20'h50000, 1, 0);
    doReq("R4 setlk", 3, 20'h50000, 1, 0);
    doReq("R4 rd", 6, 20'h50002, 1, 1);
    doReq("R4 chip", 2, 20'h0, 1, 0);
    doReq("R4 perm", 5, 20'h0, 1, 0);
    doReq("R4 rd perm", 6, 20'h3, 1, 1);

    // random mix, no set-permanent
    for (int n = 0; n < 400; n++) begin
      int r  = int'($urandom(seed) % 7);
      int op = (r == 5) ? 6 : r;
      int b  = int'($urandom() % 39);
      logic [19:0] a = baseOf(b) | 20'($urandom() & ((b < 8) ? 32'hFFF : 32'h7FFF));
      if (op == 6 && ($urandom() % 2 == 0)) a = baseOf(b) | 20'd2;
      doReq("R3 R5 R9 random", op, a, logic'($urandom() % 2), logic'(($urandom() % 8) != 0));
    end

    // R8 chip erase
    doReq("R5 clear", 4, 20'h0, 1, 1);
    doReq("R8 chip none", 2, 20'h0, 0, 1);
    for (int b = 2; b < 39; b++) doReq("R5 set all", 3, baseOf(b) | 20'h40, 1, 1);
    doReq("R8 chip wp high", 2, 20'h0, 1, 1);
    doReq("R8 chip wp low", 2, 20'h0, 0, 1);
    doReq("R5 set b0", 3, 20'h0, 1, 1);
    doReq("R5 set b1", 3, 20'h1000, 1, 1);
    doReq("R8 chip all", 2, 20'h0, 1, 1);
    doReq("R5 clear all", 4, 20'h7, 1, 1);
    doReq("R5 rd after clear", 6, 20'hF8002, 1, 1);
    doReq("R8 chip after clear", 2, 20'h0, 0, 1);

    // R7 soft reset preserves locks
    doReq("R5 set b20", 3, baseOf(20), 1, 1);
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 soft reset valid", 8'(respValid), 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    doReq("R7 lock kept", 6, baseOf(20) | 20'd2, 1, 1);

    // R6 permanent bit
    doReq("R7 set perm", 5, 20'h12345, 1, 1);
    doReq("R9 rd perm", 6, 20'h3, 1, 1);
    doReq("R6 setlk", 3, baseOf(21), 1, 1);
    doReq("R6 rd b21", 6, baseOf(21) | 20'd2, 1, 1);
    doReq("R6 clrlk", 4, 20'h0, 1, 1);
    doReq("R6 rd b20", 6, baseOf(20) | 20'd2, 1, 1);
    doReq("R7 perm again", 5, 20'h0, 1, 1);
    doReq("R3 prog locked perm", 0, baseOf(20), 1, 1);

    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doReq("R7 perm after soft reset", 6, 20'h3, 1, 1);

    porN = 1'b0;
    @(negedge clk);
    porN = 1'b1;
    clearModel();
    @(negedge clk);
    doReq("R7 perm after por", 6, 20'h3, 1, 1);
    doReq("R7 lock after por", 6, baseOf(20) | 20'd2, 1, 1);
    doReq("R5 setlk after por", 3, baseOf(21), 1, 1);
    @(negedge clk);
    chk("R10 idle end", 8'(respValid), 8'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule